// File: doc/BRIEF.md
# Flash command interface with status register

This block sits between a host bus and the program/erase machinery of a flash-style memory. Bytes written on the low eight data lines are decoded as commands. They pick what a read returns (array contents, the status byte, or an identification code), flip three mode flags, or start a program or erase job. Set-up commands open a two-write sequence. The second write is either a confirm code or the word to be programmed. The main region and the overlay region each have their own set-up code, and each has its own confirm code for erase.

A small engine stands in for the real algorithms. It stays busy for a number of cycles set by an input, can be frozen by a suspend, and is killed when the program-supply-OK input drops. An 8-bit status byte reports the ready, suspend and error conditions. A read strobe returns one registered word from the selected source on the following cycle.

Top module: `fcmd_ctrl`

## Requirements
- R1: After reset the status byte is 80h, reads return array data, and the sync, wrap and overlay flags are 0.
- R2: Command FFh selects array reads, 70h status reads and 90h identification reads. In identification mode, addr bits [1:0] = 00 return 00000020h, 01 return 000000F0h and 10 return the version parameter (default 3) zero-extended.
- R3: Command 60h inverts the sync flag, 30h the wrap flag and 06h the overlay flag. Each of them selects array reads.
- R4: 20h followed by D0h starts an erase (operation code 0) at the address of the D0h write and selects status reads. Status bit 7 reads 0 for exactly N cycles after the confirm edge, where N = busy_cycles_i, with 0 treated as 1, and 1 afterwards.
- R5: After 20h, any second byte other than D0h sets status bits 5 and 4, starts nothing, and selects array reads.
- R6: 02h followed by 0Dh starts an overlay erase (operation code 2). Any other second byte sets only status bit 5 and selects array reads.
- R7: 40h (main) or 04h (overlay) followed by any write starts a program (operation code 1 or 3) and latches that write's address and 32-bit data to the engine.
- R8: While an operation runs, only B0h is acted on, and only for main-region operations. Every other command is ignored, and reads keep returning status.
- R9: B0h during a main operation sets status bits 7 and 6, plus bit 5 for an erase or bit 4 for a program, and freezes the busy count. D0h then clears those bits and bit 7, and the remaining count resumes.
- R10: If the supply-OK input is low at the confirm or data write, nothing starts and status bit 3 is set. If it drops while an operation runs or is suspended, the operation aborts, and status bits 3 and 7 are set.
- R11: 50h clears status bits 5..3 and leaves bits 7 and 6. It is accepted when idle or suspended and does not change the read source.
- R12: An unknown command, or D0h/B0h with no operation in progress, selects array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Address for reads and writes |
| data_i | input | DATA_W | Write data, command byte on [7:0] |
| array_data_i | input | DATA_W | Word from the memory array |
| vpp_ok_i | input | 1 | Program supply in range |
| busy_cycles_i | input | CNT_W | Engine busy length in cycles |
| rdata_o | output | DATA_W | Read result, registered |
| rvalid_o | output | 1 | rdata_o valid, one cycle after rd_i |
| status_o | output | 8 | Status byte |
| sync_mode_o | output | 1 | Sync read flag |
| wrap_o | output | 1 | Burst wrap flag |
| ovl_en_o | output | 1 | Overlay read enable flag |
| eng_req_o | output | 1 | Engine start pulse |
| eng_op_o | output | 2 | Operation: 0 erase, 1 program, 2 overlay erase, 3 overlay program |
| eng_addr_o | output | ADDR_W | Latched operation address |
| eng_data_o | output | DATA_W | Latched program data |
| eng_busy_o | output | 1 | Engine busy |
| eng_done_o | output | 1 | Engine completes this cycle |

## Verification
The decoder is driven with each accepted command byte, with unknown bytes, and with out-of-context confirm and suspend codes. This tells a byte that moves to array reads apart from one the decoder ignores. Operations are started with busy lengths of 0, 5 and 30, and the status is read every cycle. This pins the exact edge at which bit 7 returns to 1, and it separates a frozen count from a running one across suspend and resume. Good and bad second bytes are sent for both regions, together with supply drops before and during a job. These show that each error path sets its own bits and that the clear command spares bits 7 and 6.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam logic [7:0] C_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] C_RD_STAT   = 8'h70;
  localparam logic [7:0] C_CLR_STAT  = 8'h50;
  localparam logic [7:0] C_RD_SIG    = 8'h90;
  localparam logic [7:0] C_ERS_SU    = 8'h20;
  localparam logic [7:0] C_PRG_SU    = 8'h40;
  localparam logic [7:0] C_OERS_SU   = 8'h02;
  localparam logic [7:0] C_OPRG_SU   = 8'h04;
  localparam logic [7:0] C_SUSPEND   = 8'hB0;
  localparam logic [7:0] C_CONFIRM   = 8'hD0;
  localparam logic [7:0] C_OERS_CFM  = 8'h0D;
  localparam logic [7:0] C_TG_SYNC   = 8'h60;
  localparam logic [7:0] C_TG_WRAP   = 8'h30;
  localparam logic [7:0] C_TG_OVL    = 8'h06;

  localparam int SB_READY = 7;
  localparam int SB_SUSP  = 6;
  localparam int SB_ERS   = 5;
  localparam int SB_PRG   = 4;
  localparam int SB_VPP   = 3;

  localparam logic [31:0] ID_MFR = 32'h0000_0020;
  localparam logic [31:0] ID_DEV = 32'h0000_00F0;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_SIG} rmode_e;
  typedef enum logic [1:0] {OP_ERASE, OP_PROG, OP_OERASE, OP_OPROG} op_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ERS_CFM, ST_PRG_DAT, ST_OERS_CFM, ST_OPRG_DAT, ST_RUN, ST_SUSP
  } cst_e;
endpackage

// File: rtl/fcmd_engine.sv
module fcmd_engine
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  cycles_i,
  input  logic              hold_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              done_o,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_o && !hold_i && !abort_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
      op_o   <= OP_ERASE;
      addr_o <= '0;
      data_o <= '0;
    end else if (abort_i) begin
      busy_o <= 1'b0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= (cycles_i == '0) ? ONE : cycles_i;
      op_o   <= op_i;
      addr_o <= addr_i;
      data_o <= data_i;
    end else if (busy_o && !hold_i) begin
      if (cnt_q == ONE) busy_o <= 1'b0;
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/fcmd_rdmux.sv
module fcmd_rdmux
  import fcmd_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter logic [2:0]  SIG_VER = 3'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  rmode_e            mode_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] array_i,
  input  logic [7:0]        status_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [DATA_W-1:0] sig_w, mux_w;

  always_comb begin
    unique case (sel_i)
      2'b00:   sig_w = DATA_W'(ID_MFR);
      2'b01:   sig_w = DATA_W'(ID_DEV);
      2'b10:   sig_w = DATA_W'(SIG_VER);
      default: sig_w = '0;
    endcase
    unique case (mode_i)
      RM_STATUS: mux_w = DATA_W'(status_i);
      RM_SIG:    mux_w = sig_w;
      default:   mux_w = array_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= mux_w;
    end
  end
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] cmd_i,
  input  logic       vpp_ok_i,
  input  logic       eng_done_i,
  output logic       start_o,
  output op_e        op_o,
  output logic       hold_o,
  output logic       abort_o,
  output rmode_e     rmode_o,
  output logic [7:0] status_o,
  output logic       sync_o,
  output logic       wrap_o,
  output logic       ovl_o,
  output cst_e       state_o
);
  cst_e       st_q;
  op_e        op_q;
  logic       pending, second_ok, main_op;

  assign state_o = st_q;
  assign pending = (st_q == ST_ERS_CFM) || (st_q == ST_PRG_DAT) ||
                   (st_q == ST_OERS_CFM) || (st_q == ST_OPRG_DAT);
  assign main_op = (op_q == OP_ERASE) || (op_q == OP_PROG);

  always_comb begin
    second_ok = 1'b0;
    op_o      = op_q;
    unique case (st_q)
      ST_ERS_CFM:  begin second_ok = (cmd_i == C_CONFIRM);  op_o = OP_ERASE;  end
      ST_OERS_CFM: begin second_ok = (cmd_i == C_OERS_CFM); op_o = OP_OERASE; end
      ST_PRG_DAT:  begin second_ok = 1'b1;                  op_o = OP_PROG;   end
      ST_OPRG_DAT: begin second_ok = 1'b1;                  op_o = OP_OPROG;  end
      default: ;
    endcase
  end

  assign start_o = wr_i && pending && second_ok && vpp_ok_i;
  assign abort_o = ((st_q == ST_RUN) || (st_q == ST_SUSP)) && !vpp_ok_i;
  assign hold_o  = (st_q == ST_SUSP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_ERASE;
      rmode_o  <= RM_ARRAY;
      status_o <= 8'h80;
      sync_o   <= 1'b0;
      wrap_o   <= 1'b0;
      ovl_o    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (wr_i) begin
          unique case (cmd_i)
            C_RD_ARRAY: rmode_o <= RM_ARRAY;
            C_RD_STAT:  rmode_o <= RM_STATUS;
            C_RD_SIG:   rmode_o <= RM_SIG;
            C_CLR_STAT: status_o[SB_ERS:SB_VPP] <= 3'b000;
            C_ERS_SU:   st_q <= ST_ERS_CFM;
            C_PRG_SU:   st_q <= ST_PRG_DAT;
            C_OERS_SU:  st_q <= ST_OERS_CFM;
            C_OPRG_SU:  st_q <= ST_OPRG_DAT;
            C_TG_SYNC:  begin sync_o <= !sync_o; rmode_o <= RM_ARRAY; end
            C_TG_WRAP:  begin wrap_o <= !wrap_o; rmode_o <= RM_ARRAY; end
            C_TG_OVL:   begin ovl_o  <= !ovl_o;  rmode_o <= RM_ARRAY; end
            default:    rmode_o <= RM_ARRAY;
          endcase
        end
        ST_ERS_CFM, ST_PRG_DAT, ST_OERS_CFM, ST_OPRG_DAT: if (wr_i) begin
          if (second_ok) begin
            rmode_o <= RM_STATUS;
            if (vpp_ok_i) begin
              st_q               <= ST_RUN;
              op_q               <= op_o;
              status_o[SB_READY] <= 1'b0;
            end else begin
              st_q             <= ST_IDLE;
              status_o[SB_VPP] <= 1'b1;
            end
          end else begin
            st_q             <= ST_IDLE;
            rmode_o          <= RM_ARRAY;
            status_o[SB_ERS] <= 1'b1;
            if (st_q == ST_ERS_CFM) status_o[SB_PRG] <= 1'b1;
          end
        end
        ST_RUN: begin
          if (!vpp_ok_i) begin
            st_q               <= ST_IDLE;
            status_o[SB_VPP]   <= 1'b1;
            status_o[SB_READY] <= 1'b1;
          end else if (eng_done_i) begin
            st_q               <= ST_IDLE;
            status_o[SB_READY] <= 1'b1;
          end else if (wr_i && cmd_i == C_SUSPEND && main_op) begin
            st_q               <= ST_SUSP;
            status_o[SB_READY] <= 1'b1;
            status_o[SB_SUSP]  <= 1'b1;
            if (op_q == OP_ERASE) status_o[SB_ERS] <= 1'b1;
            else                  status_o[SB_PRG] <= 1'b1;
          end
        end
        ST_SUSP: begin
          if (!vpp_ok_i) begin
            st_q               <= ST_IDLE;
            status_o[SB_VPP]   <= 1'b1;
            status_o[SB_SUSP]  <= 1'b0;
            status_o[SB_READY] <= 1'b1;
          end else if (wr_i) begin
            unique case (cmd_i)
              C_CONFIRM: begin
                st_q               <= ST_RUN;
                rmode_o            <= RM_STATUS;
                status_o[SB_READY] <= 1'b0;
                status_o[SB_SUSP]  <= 1'b0;
                if (op_q == OP_ERASE) status_o[SB_ERS] <= 1'b0;
                else                  status_o[SB_PRG] <= 1'b0;
              end
              C_RD_ARRAY: rmode_o <= RM_ARRAY;
              C_RD_STAT:  rmode_o <= RM_STATUS;
              C_RD_SIG:   rmode_o <= RM_SIG;
              C_CLR_STAT: status_o[SB_ERS:SB_VPP] <= 3'b000;
              default: ;
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int         ADDR_W  = 18,
  parameter int         DATA_W  = 32,
  parameter int         CNT_W   = 16,
  parameter logic [2:0] SIG_VER = 3'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              vpp_ok_i,
  input  logic [CNT_W-1:0]  busy_cycles_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [7:0]        status_o,
  output logic              sync_mode_o,
  output logic              wrap_o,
  output logic              ovl_en_o,
  output logic              eng_req_o,
  output logic [1:0]        eng_op_o,
  output logic [ADDR_W-1:0] eng_addr_o,
  output logic [DATA_W-1:0] eng_data_o,
  output logic              eng_busy_o,
  output logic              eng_done_o
);
  op_e    dec_op, eng_op;
  logic   hold, abort;
  rmode_e rmode;
  cst_e   dec_state;

  assign eng_op_o = eng_op;

  fcmd_decoder u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .cmd_i      (data_i[7:0]),
    .vpp_ok_i   (vpp_ok_i),
    .eng_done_i (eng_done_o),
    .start_o    (eng_req_o),
    .op_o       (dec_op),
    .hold_o     (hold),
    .abort_o    (abort),
    .rmode_o    (rmode),
    .status_o   (status_o),
    .sync_o     (sync_mode_o),
    .wrap_o     (wrap_o),
    .ovl_o      (ovl_en_o),
    .state_o    (dec_state)
  );

  fcmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (eng_req_o),
    .op_i     (dec_op),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .cycles_i (busy_cycles_i),
    .hold_i   (hold),
    .abort_i  (abort),
    .busy_o   (eng_busy_o),
    .done_o   (eng_done_o),
    .op_o     (eng_op),
    .addr_o   (eng_addr_o),
    .data_o   (eng_data_o)
  );

  fcmd_rdmux #(.DATA_W(DATA_W), .SIG_VER(SIG_VER)) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_i),
    .mode_i   (rmode),
    .sel_i    (addr_i[1:0]),
    .array_i  (array_data_i),
    .status_i (status_o),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );
endmodule

// File: rtl/fcmd_ctrl_chk.sv
module fcmd_ctrl_chk
  import fcmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic [7:0] cmd_i,
  input logic       vpp_ok_i,
  input logic [7:0] status_i,
  input logic       busy_i,
  input logic       done_i,
  input logic       req_i,
  input logic       hold_i,
  input rmode_e     rmode_i,
  input cst_e       state_i,
  input logic [1:0] op_i
);
  p_ready_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !hold_i |-> !status_i[7]);

  p_done_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> status_i[7]);

  p_bad_confirm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && state_i == ST_ERS_CFM && cmd_i != C_CONFIRM
    |=> status_i[5:4] == 2'b11 && rmode_i == RM_ARRAY);

  p_status_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !hold_i |-> rmode_i == RM_STATUS);

  p_suspend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && cmd_i == C_SUSPEND && state_i == ST_RUN && vpp_ok_i && !done_i && !op_i[1]
    |=> status_i[7:6] == 2'b11);

  p_start_vpp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> vpp_ok_i);

  p_vpp_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !vpp_ok_i |=> status_i[3] && status_i[7] && !busy_i);

  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && cmd_i == C_CLR_STAT && vpp_ok_i && (state_i == ST_IDLE || state_i == ST_SUSP)
    |=> status_i[5:3] == 3'b000 && status_i[7:6] == $past(status_i[7:6]));
endmodule

bind fcmd_ctrl fcmd_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .cmd_i    (data_i[7:0]),
  .vpp_ok_i (vpp_ok_i),
  .status_i (status_o),
  .busy_i   (eng_busy_o),
  .done_i   (eng_done_o),
  .req_i    (eng_req_o),
  .hold_i   (hold),
  .rmode_i  (rmode),
  .state_i  (dec_state),
  .op_i     (eng_op_o)
);

// File: tb/fcmd_ctrl_test.sv
`timescale 1ns/1ps
module fcmd_ctrl_test;
  localparam int AW = 18;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam logic [31:0] ARR = 32'h1234_ABCD;

  logic          clk = 1'b0;
  logic          rst_n, wr_en, rd_en, vpp_ok;
  logic [AW-1:0] addr;
  logic [DW-1:0] data, rdata, eng_addr_unused;
  logic [CW-1:0] busy_n;
  logic          rvalid, sync_m, wrap_m, ovl_m, eng_req, eng_busy, eng_done;
  logic [7:0]    status;
  logic [1:0]    eng_op;
  logic [AW-1:0] eng_addr;
  logic [DW-1:0] eng_data;

  always #4 clk = ~clk;

  fcmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_en), .rd_i(rd_en), .addr_i(addr),
    .data_i(data), .array_data_i(ARR), .vpp_ok_i(vpp_ok), .busy_cycles_i(busy_n),
    .rdata_o(rdata), .rvalid_o(rvalid), .status_o(status), .sync_mode_o(sync_m),
    .wrap_o(wrap_m), .ovl_en_o(ovl_m), .eng_req_o(eng_req), .eng_op_o(eng_op),
    .eng_addr_o(eng_addr), .eng_data_o(eng_data), .eng_busy_o(eng_busy),
    .eng_done_o(eng_done)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    addr = a; data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: queue the expected word, monitor compares it when rvalid arrives
  task automatic rd(logic [AW-1:0] a, logic [31:0] e, string req);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_raw(output logic [31:0] v);
    addr = '0; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poll_ready(string req);
    logic [31:0] v;
    v = 32'h0;
    for (int n = 0; n < 80 && !v[7]; n++) rd_raw(v);
    chk(req, v, 32'h80);
    idle(1);
  endtask

  always @(negedge clk) begin
    if (rst_n && rvalid && exp_q.size() > 0) begin
      string t;
      logic [31:0] e;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      chk(t, rdata, e);
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    eng_addr_unused = '0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; vpp_ok = 1'b1;
    addr = '0; data = '0; busy_n = CW'(5);
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 status", {24'h0, status}, 32'h80);
    chk("R1 flags", {29'h0, sync_m, wrap_m, ovl_m}, 32'h0);
    rd(18'h5, ARR, "R1 array read");

    // R2 read modes and signature codes
    wr(0, 32'h70); rd(0, 32'h80, "R2 status read");
    wr(0, 32'h90);
    rd(18'h100, 32'h20, "R2 sig 00");
    rd(18'h101, 32'hF0, "R2 sig 01");
    rd(18'h102, 32'h03, "R2 sig 10");
    wr(0, 32'hAA); rd(18'h7, ARR, "R12 unknown code to array");

    // R3 toggles
    wr(0, 32'h90);
    wr(0, 32'h60); chk("R3 sync", {31'h0, sync_m}, 1);
    rd(18'h1, ARR, "R3 toggle selects array");
    wr(0, 32'h30); chk("R3 wrap", {31'h0, wrap_m}, 1);
    wr(0, 32'h06); chk("R3 overlay", {31'h0, ovl_m}, 1);
    wr(0, 32'h60); chk("R3 sync back", {31'h0, sync_m}, 0);

    // R4 erase timing, N=5
    busy_n = CW'(5);
    wr(0, 32'h20); wr(18'h04000, 32'hD0);
    chk("R4 op", {30'h0, eng_op}, 0);
    chk("R4 addr", {14'h0, eng_addr}, 32'h04000);
    for (int i = 0; i < 5; i++) rd(0, 32'h00, "R4 busy");
    rd(0, 32'h80, "R4 ready");

    // R4 zero length behaves as one cycle
    busy_n = CW'(0);
    wr(0, 32'h20); wr(0, 32'hD0);
    rd(0, 32'h00, "R4 N0 busy"); rd(0, 32'h80, "R4 N0 ready");

    // R5 bad erase confirm
    busy_n = CW'(5);
    wr(0, 32'h20); wr(0, 32'h55);
    chk("R5 no start", {31'h0, eng_busy}, 0);
    rd(18'h3, ARR, "R5 array mode");
    wr(0, 32'h70); rd(0, 32'hB0, "R5 bits 5,4");
    wr(0, 32'h50); rd(0, 32'h80, "R11 clear");

    // R6 overlay erase
    wr(0, 32'h02); wr(0, 32'h33);
    rd(18'h2, ARR, "R6 array mode");
    wr(0, 32'h70); rd(0, 32'hA0, "R6 bit 5 only");
    wr(0, 32'h50);
    wr(0, 32'h02); wr(18'h00010, 32'h0D);
    chk("R6 op", {30'h0, eng_op}, 2);
    wr(0, 32'hB0);                          // R8 no suspend on overlay
    for (int i = 0; i < 4; i++) rd(0, 32'h00, "R8 overlay not suspended");
    rd(0, 32'h80, "R6 overlay done");

    // R7 program with ignored command during run
    busy_n = CW'(4);
    wr(0, 32'h40); wr(18'h00123, 32'hDEAD_BEEF);
    chk("R7 op", {30'h0, eng_op}, 1);
    chk("R7 addr", {14'h0, eng_addr}, 32'h123);
    chk("R7 data", eng_data, 32'hDEAD_BEEF);
    wr(0, 32'hFF);                          // R8 ignored while running
    for (int i = 0; i < 3; i++) rd(0, 32'h00, "R8 status while running");
    rd(0, 32'h80, "R7 program done");
    wr(0, 32'h04); wr(18'h00200, 32'h5555_0000);
    chk("R7 overlay op", {30'h0, eng_op}, 3);
    idle(8);

    // R9 suspend / resume erase
    busy_n = CW'(30);
    wr(0, 32'h20); wr(0, 32'hD0);
    for (int i = 0; i < 3; i++) rd(0, 32'h00, "R9 running");
    wr(0, 32'hB0);
    rd(0, 32'hE0, "R9 suspended erase");
    idle(40);
    rd(0, 32'hE0, "R9 count frozen");
    chk("R9 engine held", {31'h0, eng_busy}, 1);
    wr(0, 32'h50); rd(0, 32'hC0, "R11 clear keeps 7,6");
    wr(0, 32'hD0); rd(0, 32'h00, "R9 resumed");
    poll_ready("R9 erase completes");

    // R9 suspend program
    wr(0, 32'h40); wr(0, 32'h1);
    wr(0, 32'hB0); rd(0, 32'hD0, "R9 suspended program");
    wr(0, 32'hD0); rd(0, 32'h00, "R9 program resumed");
    poll_ready("R9 program completes");

    // R10 supply low at start
    vpp_ok = 1'b0;
    wr(0, 32'h40); wr(0, 32'h77);
    chk("R10 nothing started", {31'h0, eng_busy}, 0);
    rd(0, 32'h88, "R10 vpp at start");
    vpp_ok = 1'b1;
    wr(0, 32'h50); rd(0, 32'h80, "R11 clear bit 3");

    // R10 supply drop mid-operation
    wr(0, 32'h20); wr(0, 32'hD0);
    idle(3);
    vpp_ok = 1'b0; idle(1); vpp_ok = 1'b1;
    chk("R10 aborted", {31'h0, eng_busy}, 0);
    rd(0, 32'h88, "R10 vpp drop");
    wr(0, 32'h50);

    // R12 out-of-context confirm / suspend
    wr(0, 32'h90); wr(0, 32'hD0); rd(18'h1, ARR, "R12 stray confirm");
    wr(0, 32'h70); wr(0, 32'hB0); rd(18'h1, ARR, "R12 stray suspend");

    idle(3);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule